// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This peripheral holds two independent 16-bit up-counters. Each counter advances at a rate set by its own divider. When it reaches or passes its own limit value, it falls back to zero. A host reaches the block through a synchronous register port: an 8-bit address, 16-bit write data, a write strobe and a combinational read-data output. Each counter can be read and reloaded at any time.

When a counter falls back to zero and its enable bit is set, the block emits a one-cycle request on a fixed line of an 8-bit interrupt request vector. Counter 0 uses line 1 and counter 1 uses line 5. An arbiter outside the block latches and prioritises these lines. Typical use is to program the divider and the limit, set the enable, and then write the counter to start a clean period.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous active-low reset, every decoded register reads 0 and all bits of `irq_vec` are 0.
- R2: The register addresses are fixed. Divider 0 is at 0x04 and divider 1 at 0x05. Limit 0 is at 0x06 and limit 1 at 0x07. Count 0 is at 0x08 and count 1 at 0x09. The enable register is at 0x0A, where bit 0 serves counter 0 and bit 1 serves counter 1. A value written to a divider, a limit or the enable bits reads back unchanged.
- R3: A counter advances once every D clock cycles, where D is its divider value. A divider of 0 behaves exactly like a divider of 1.
- R4: On each advance, a count that is greater than or equal to its limit becomes 0. Any other count increments by one. A count written above the limit therefore clears on the next advance.
- R5: When a counter falls back to zero and its enable bit is 1, its request line is high for exactly the cycle in which the count first reads 0. When the enable bit is 0, no request is raised.
- R6: Counter 0 drives `irq_vec[1]` and counter 1 drives `irq_vec[5]`. The other six bits stay 0. The two counters run independently.
- R7: A read from any address outside 0x04 to 0x0A returns 0xFFFF. A write to such an address changes no register.
- R8: A count write in the same cycle as an advance takes precedence: the written value is loaded, and that cycle produces no fall-back and no request.
- R9: A count write restarts that counter's divider phase. The first advance after the write comes D cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wen | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_vec | output | 8 | One-cycle interrupt requests on fixed lines |

## Verification
A host write to a count register can land on the same edge at which that counter advances and would otherwise fall back to zero. The bench provokes this by setting the divider to 1 and the limit to 0, so that every edge is a fall-back edge, and then writing the count. It judges the result by requiring that the cycle after the write shows the written value with the request line low, and that the following cycle shows a zero count with the request line high. Phase restart is checked the same way: a count write lands mid-period with a divider of 4, and the first advance must come four edges later.

// File: rtl/ivt_pkg.sv
// Package: shared constants, field codes and address decode for the
// dual interval timer. Assumes the register window starts at IVT_BASE
// and is laid out as divider, limit and count groups of IVT_CH entries,
// followed by one enable register.
package ivt_pkg;
    localparam int unsigned IVT_CH   = 2;
    localparam int unsigned IVT_DW   = 16;
    localparam int unsigned IVT_AW   = 8;
    localparam int unsigned IVT_CW   = (IVT_CH > 1) ? $clog2(IVT_CH) : 1;
    localparam logic [IVT_AW-1:0] IVT_BASE = 8'h04;
    localparam int unsigned IVT_SPAN = 3 * IVT_CH + 1;

    typedef enum logic [1:0] {
        FLD_DIV = 2'd0,
        FLD_LIM = 2'd1,
        FLD_CNT = 2'd2,
        FLD_ENA = 2'd3
    } ivt_field_e;

    typedef struct packed {
        logic             hit;
        ivt_field_e       fld;
        logic [IVT_CW-1:0] ch;
    } ivt_dec_t;

    // Map an address onto field and channel; hit is low outside the window.
    function automatic ivt_dec_t ivt_decode(input logic [IVT_AW-1:0] a);
        ivt_dec_t    d;
        int unsigned off;
        d.hit = 1'b0;
        d.fld = FLD_DIV;
        d.ch  = '0;
        if (a >= IVT_BASE) begin
            off = int'(a - IVT_BASE);
            if (off < 3 * IVT_CH) begin
                d.hit = 1'b1;
                d.fld = ivt_field_e'(off / IVT_CH);
                d.ch  = IVT_CW'(off % IVT_CH);
            end else if (off == 3 * IVT_CH) begin
                d.hit = 1'b1;
                d.fld = FLD_ENA;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/ivt_prescaler.sv
// Divider phase counter for one channel. It issues a one-cycle tick
// every max(div_val,1) cycles. A restart puts the phase back to zero.
// Assumes div_val may change at any time; a phase already past the new
// end ticks on the next cycle.
module ivt_prescaler #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_val,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] phase_q;
    logic [W-1:0] last_phase;

    // Last phase of the period, with a divider of 0 treated as 1.
    always_comb begin
        last_phase = (div_val == '0) ? '0 : div_val - W'(1);
        tick       = (phase_q >= last_phase);
    end

    // Phase register: restart and period end both return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (tick)    phase_q <= '0;
        else              phase_q <= phase_q + W'(1);
    end
endmodule

// File: rtl/ivt_counter.sv
// Count register for one channel. On a tick it clears when at or above
// the limit and increments otherwise. A host load always wins over a
// tick, and a loaded cycle never reports a wrap.
module ivt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] lim_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // Wrap condition for the current advance.
    always_comb wrap = tick && !load && (cnt >= lim_val);

    // Count update with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= wrap ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/ivt_regbank.sv
// Host register bank: holds dividers, limits and enable bits, turns
// count writes into load strobes and builds the read data. Assumes a
// single-cycle write strobe and a combinational read. Undecoded reads
// return all ones; undecoded writes are dropped.
module ivt_regbank
    import ivt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IVT_AW-1:0]             addr,
    input  logic                          wen,
    input  logic [IVT_DW-1:0]             wdata,
    input  logic [IVT_CH-1:0][IVT_DW-1:0] cnt_vals,
    output logic [IVT_CH-1:0][IVT_DW-1:0] div_vals,
    output logic [IVT_CH-1:0][IVT_DW-1:0] lim_vals,
    output logic [IVT_CH-1:0]             ena,
    output logic [IVT_CH-1:0]             cnt_load,
    output logic [IVT_DW-1:0]             rdata
);
    ivt_dec_t dec;
    logic     unused_wdata_hi;

    // Decode the address once for both paths.
    always_comb dec = ivt_decode(addr);

    // Upper write-data bits have no home in the enable register.
    assign unused_wdata_hi = ^wdata[IVT_DW-1:IVT_CH];

    for (genvar c = 0; c < IVT_CH; c++) begin : g_ch
        logic sel;
        // Channel select for this slot.
        always_comb sel = wen && dec.hit && (dec.ch == IVT_CW'(c));

        // Divider and limit storage for one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                div_vals[c] <= '0;
                lim_vals[c] <= '0;
            end else if (sel && dec.fld == FLD_DIV) begin
                div_vals[c] <= wdata;
            end else if (sel && dec.fld == FLD_LIM) begin
                lim_vals[c] <= wdata;
            end
        end

        // Count load strobe for this channel.
        always_comb cnt_load[c] = sel && (dec.fld == FLD_CNT);
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ena <= '0;
        else if (wen && dec.hit && dec.fld == FLD_ENA) ena <= wdata[IVT_CH-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '1;
        if (dec.hit) begin
            unique case (dec.fld)
                FLD_DIV: rdata = div_vals[dec.ch];
                FLD_LIM: rdata = lim_vals[dec.ch];
                FLD_CNT: rdata = cnt_vals[dec.ch];
                FLD_ENA: rdata = {{(IVT_DW-IVT_CH){1'b0}}, ena};
            endcase
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
// Top: two prescaled interval timers behind a register port. Each wrap
// with its enable set becomes a registered one-cycle pulse on a fixed
// line of irq_vec. Assumes T0_LINE and T1_LINE are distinct and lie
// below IRQ_W.
module dual_interval_timer
    import ivt_pkg::*;
#(
    parameter int unsigned IRQ_W   = 8,
    parameter int unsigned T0_LINE = 1,
    parameter int unsigned T1_LINE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVT_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [IVT_DW-1:0] reg_wdata,
    output logic [IVT_DW-1:0] reg_rdata,
    output logic [IRQ_W-1:0]  irq_vec
);
    logic [IVT_CH-1:0][IVT_DW-1:0] div_vals;
    logic [IVT_CH-1:0][IVT_DW-1:0] lim_vals;
    logic [IVT_CH-1:0][IVT_DW-1:0] cnt_val;
    logic [IVT_CH-1:0]             ena;
    logic [IVT_CH-1:0]             cnt_load;
    logic [IVT_CH-1:0]             wrap;
    logic [IVT_CH-1:0]             pulse_q;

    ivt_regbank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wen      (reg_wen),
        .wdata    (reg_wdata),
        .cnt_vals (cnt_val),
        .div_vals (div_vals),
        .lim_vals (lim_vals),
        .ena      (ena),
        .cnt_load (cnt_load),
        .rdata    (reg_rdata)
    );

    for (genvar c = 0; c < IVT_CH; c++) begin : g_tmr
        logic tick;

        ivt_prescaler #(.W(IVT_DW)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .div_val (div_vals[c]),
            .restart (cnt_load[c]),
            .tick    (tick)
        );

        ivt_counter #(.W(IVT_DW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .lim_val  (lim_vals[c]),
            .load     (cnt_load[c]),
            .load_val (reg_wdata),
            .cnt      (cnt_val[c]),
            .wrap     (wrap[c])
        );

        // Request pulse, registered so it coincides with the zero count.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse_q[c] <= 1'b0;
            else        pulse_q[c] <= wrap[c] && ena[c];
        end
    end

    // Route each channel's pulse onto its fixed request line.
    always_comb begin
        irq_vec          = '0;
        irq_vec[T0_LINE] = pulse_q[0];
        irq_vec[T1_LINE] = pulse_q[1];
    end
endmodule

// File: rtl/ivt_checker.sv
// Checker for dual_interval_timer: port-level and count-register
// properties, attached to every instance through bind.
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int unsigned IRQ_W   = 8,
    parameter int unsigned T0_LINE = 1,
    parameter int unsigned T1_LINE = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [IVT_AW-1:0]             reg_addr,
    input logic                          reg_wen,
    input logic [IVT_DW-1:0]             reg_wdata,
    input logic [IVT_DW-1:0]             reg_rdata,
    input logic [IRQ_W-1:0]              irq_vec,
    input logic [IVT_CH-1:0][IVT_DW-1:0] cnt_val
);
    localparam logic [IRQ_W-1:0] LINE_MASK =
        (IRQ_W'(1) << T0_LINE) | (IRQ_W'(1) << T1_LINE);
    localparam logic [IVT_AW-1:0] CNT0_A = IVT_BASE + IVT_AW'(2 * IVT_CH);
    localparam logic [IVT_AW-1:0] LAST_A = IVT_BASE + IVT_AW'(IVT_SPAN - 1);

    assert_unused_lines_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & ~LINE_MASK) == '0);

    assert_req_with_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec[T0_LINE] |-> cnt_val[0] == '0);

    assert_undecoded_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < IVT_BASE || reg_addr > LAST_A) |-> reg_rdata == 16'hFFFF);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == CNT0_A) |=>
            (cnt_val[0] == $past(reg_wdata) && !irq_vec[T0_LINE]));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(reg_wen) && $past(reg_addr) == CNT0_A)
            && !$stable(cnt_val[0]))
        |-> (cnt_val[0] == '0 || cnt_val[0] == IVT_DW'($past(cnt_val[0]) + 1)));
endmodule

bind dual_interval_timer ivt_checker #(
    .IRQ_W   (IRQ_W),
    .T0_LINE (T0_LINE),
    .T1_LINE (T1_LINE)
) u_ivt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_vec   (irq_vec),
    .cnt_val   (cnt_val)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [7:0]  irq_vec;

    int errs = 0;
    int checks = 0;
    int mdiv[2], mlim[2], mcnt[2], mph[2], men[2];
    int line_of[2] = '{1, 5};

    always #4 clk = ~clk;

    dual_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_vec(irq_vec)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one register; updates the model's view of the map (R2).
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(posedge clk);
        case (a)
            8'h04: mdiv[0] = d;  8'h05: mdiv[1] = d;
            8'h06: mlim[0] = d;  8'h07: mlim[1] = d;
            8'h08: begin mcnt[0] = d; mph[0] = 0; end
            8'h09: begin mcnt[1] = d; mph[1] = 0; end
            8'h0A: begin men[0] = d[0]; men[1] = d[1]; end
            default: ;
        endcase
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1 check(tag, reg_rdata, exp);
    endtask

    // Step the model n edges; compare count and the whole request vector.
    task automatic run(input int ch, input int n, input string tag);
        reg_addr = 8'h08 + 8'(ch);
        for (int i = 0; i < n; i++) begin
            logic w;
            logic [7:0] ev;
            int last = (mdiv[ch] == 0) ? 0 : mdiv[ch] - 1;
            w = 1'b0;
            if (mph[ch] >= last) begin
                mph[ch] = 0;
                w = (mcnt[ch] >= mlim[ch]);
                mcnt[ch] = w ? 0 : (mcnt[ch] + 1) & 16'hFFFF;
            end else mph[ch]++;
            ev = '0;
            ev[line_of[ch]] = w && men[ch] != 0;
            @(negedge clk);
            #1;
            check({tag, " count"}, reg_rdata, 16'(mcnt[ch]));
            check({tag, " irq"}, {8'h00, irq_vec}, {8'h00, ev});
        end
    endtask

    task automatic t_reset;
        for (int a = 4; a <= 10; a++) rd_check(8'(a), 16'h0000, "R1 reset value");
        check("R1 irq idle", {8'h00, irq_vec}, 16'h0000);
    endtask

    task automatic t_readback;
        wr(8'h05, 16'h1234); wr(8'h07, 16'hBEEF); wr(8'h0A, 16'h0003);
        rd_check(8'h05, 16'h1234, "R2 divider1");
        rd_check(8'h07, 16'hBEEF, "R2 limit1");
        rd_check(8'h0A, 16'h0003, "R2 enables");
        wr(8'h0A, 16'h0000);
    endtask

    task automatic t_basic;
        wr(8'h04, 16'd3); wr(8'h06, 16'd5); wr(8'h0A, 16'h0001);
        wr(8'h08, 16'd0);
        run(0, 22, "R3 R5 divide3 limit5");
    endtask

    task automatic t_div_zero;
        wr(8'h04, 16'd0); wr(8'h06, 16'd3);
        wr(8'h08, 16'd0);
        run(0, 10, "R3 divider0 as 1");
    endtask

    task automatic t_above_lim;
        wr(8'h04, 16'd2); wr(8'h06, 16'd5);
        wr(8'h08, 16'd9);
        run(0, 5, "R4 above limit");
    endtask

    task automatic t_disabled;
        wr(8'h0A, 16'h0000); wr(8'h04, 16'd1); wr(8'h06, 16'd2);
        wr(8'h08, 16'd0);
        run(0, 8, "R5 disabled no req");
    endtask

    task automatic t_timer1;
        wr(8'h05, 16'd2); wr(8'h07, 16'd2); wr(8'h0A, 16'h0002);
        wr(8'h09, 16'd0);
        run(1, 14, "R6 timer1 line5");
        wr(8'h0A, 16'h0000);
    endtask

    task automatic t_undecoded;
        wr(8'h04, 16'h00A5);
        wr(8'h00, 16'hFFFF); wr(8'h0B, 16'hFFFF); wr(8'h03, 16'h5555);
        rd_check(8'h04, 16'h00A5, "R7 divider0 untouched");
        rd_check(8'h06, 16'h0002, "R7 limit0 untouched");
        rd_check(8'h0A, 16'h0000, "R7 enables untouched");
        rd_check(8'h00, 16'hFFFF, "R7 read 0x00");
        rd_check(8'h03, 16'hFFFF, "R7 read 0x03");
        rd_check(8'h0B, 16'hFFFF, "R7 read 0x0B");
        rd_check(8'hFF, 16'hFFFF, "R7 read 0xFF");
    endtask

    task automatic t_collision;
        wr(8'h04, 16'd1); wr(8'h06, 16'd0); wr(8'h0A, 16'h0001);
        wr(8'h08, 16'd0);
        run(0, 3, "R8 pre-collision");
        wr(8'h08, 16'd7);
        #1;
        check("R8 write wins count", reg_rdata, 16'd7);
        check("R8 write wins no irq", {8'h00, irq_vec}, 16'h0000);
        run(0, 3, "R8 after collision");
        wr(8'h0A, 16'h0000);
    endtask

    task automatic t_restart;
        wr(8'h04, 16'd4); wr(8'h06, 16'd100);
        wr(8'h08, 16'd10);
        run(0, 6, "R9 first period");
        wr(8'h08, 16'd20);
        run(0, 9, "R9 phase restarted");
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            mdiv[c] = 0; mlim[c] = 0; mcnt[c] = 0; mph[c] = 0; men[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_basic();
        t_div_zero();
        t_above_lim();
        t_disabled();
        t_timer1();
        t_undecoded();
        t_collision();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule